// File: doc/BRIEF.md
# CPU Interrupt Status/Cause Prioritizer

This block is the interrupt-gathering front end of a processor core. It combines eight interrupt lines into one request to the core. The lower two lines are software interrupts: code raises or drops them by writing a cause register. The upper six lines are hardware levels from the chip, and the topmost line can also be driven by a compare-match pulse from the core timer. Each line has an enable bit in a status register. A single global enable bit in that same register gates the final request.

Both registers are reached through a small register port: one address word, one write strobe, and a read path that reflects the current state in the same cycle. From the registers and the live hardware levels the block forms the effective set: lines that are both pending and enabled. It reports whether this set is non-empty and gives the index of its highest-numbered member. When the core starts interrupt dispatch while the effective set is empty, the block raises a one-cycle spurious flag.

Top module: `irq_status_cause`

## Requirements
- R1: After reset, the status register reads 0, the software pending bits (cause bits 8 and 9) read 0, and `irqReq` is low.
- R2: A write to address 0 (status) stores bit 0 as the global enable and bits 15:8 as the enable field, with line n at bit 8+n. All other status bits read as 0. A write to an address other than 0 or 1 changes neither register.
- R3: A write to address 1 (cause) updates only the software pending bits, bits 8 and 9 (lines 0 and 1). Writes to cause bits 10 to 15 and to every other cause bit are ignored.
- R4: Cause bits 10 to 15 read back the current level of hardware lines 2 to 7 (`hwIrq[n-2]` at bit 8+n) in the same cycle, with no storage. Writing the cause register cannot clear them.
- R5: With `TIMER_ON_TOP` set (the default), line 7 is pending while either `hwIrq[5]` or `timerMatch` is high.
- R6: `irqValid` is high exactly when the bitwise AND of the pending field and the enable field is non-zero. When that set is empty, `irqIdx` is 0.
- R7: `irqReq` is high exactly when `irqValid` is high and the global enable bit is set.
- R8: `irqIdx` gives the highest-numbered line in the effective set. It is combinational from the register state and the input levels.
- R9: If `dispatch` is high in a cycle where `irqValid` is low, `spurious` is high for exactly the following cycle. Otherwise `spurious` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register address: 0 status, 1 cause |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for the addressed register, combinational |
| hwIrq | input | 6 | Level inputs for hardware lines 2 to 7 |
| timerMatch | input | 1 | Timer compare-match level, merged into line 7 |
| dispatch | input | 1 | Core is entering interrupt dispatch this cycle |
| irqReq | output | 1 | Interrupt request to the core |
| irqIdx | output | 3 | Highest-numbered effective pending line |
| irqValid | output | 1 | Effective pending set is non-empty |
| spurious | output | 1 | Dispatch happened with an empty effective set |

## Verification
The hardest case to reach is a hardware line that stays pending while software tries to clear it. The stimulus holds `hwIrq` high on two lines, writes all ones and then all zeros to the cause register, and checks that only bits 8 and 9 follow the writes. A second difficult case is a spurious dispatch. The stimulus gets there in two steps: it keeps lines pending, then clears the whole enable field so that pending bits are still visible in the cause read while the effective set is empty. Dispatch is then pulsed once in that state and once with a valid line, to check that the flag is raised only in the empty case.

// File: rtl/irq_sc_pkg.sv
package irq_sc_pkg;
  localparam int NUM_LINES  = 8;
  localparam int SW_LINES   = 2;
  localparam int HW_LINES   = NUM_LINES - SW_LINES;
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int FIELD_LSB  = 8;
  localparam int FIELD_MSB  = FIELD_LSB + NUM_LINES - 1;
  localparam int GIE_BIT    = 0;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_CAUSE  = 1;

  typedef struct packed {
    logic wrStatus;
    logic wrCause;
  } irq_strobe_t;
endpackage

// File: rtl/irq_sc_ctrl.sv
module irq_sc_ctrl
  import irq_sc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              dispatch,
  input  logic              effValid,
  output irq_strobe_t       strobes,
  output logic              spurious
);
  logic isStatus;
  logic isCause;
  logic spuriousQ;

  assign isStatus = (regAddr == ADDR_W'(ADDR_STATUS));
  assign isCause  = (regAddr == ADDR_W'(ADDR_CAUSE));

  always_comb begin
    strobes          = '0;
    strobes.wrStatus = regWrEn && isStatus;
    strobes.wrCause  = regWrEn && isCause;
  end

  always_ff @(posedge clk) begin
    if (!rstN) spuriousQ <= 1'b0;
    else       spuriousQ <= dispatch && !effValid;
  end

  assign spurious = spuriousQ;
endmodule

// File: rtl/irq_sc_datapath.sv
module irq_sc_datapath
  import irq_sc_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 32,
  parameter bit TIMER_ON_TOP = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irq_strobe_t          strobes,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 wrGie,
  input  logic [NUM_LINES-1:0] wrEnable,
  input  logic [SW_LINES-1:0]  wrSwPend,
  input  logic [HW_LINES-1:0]  hwIrq,
  input  logic                 timerMatch,
  output logic                 gie,
  output logic [NUM_LINES-1:0] enField,
  output logic [SW_LINES-1:0]  swPend,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [DATA_W-1:0]    regRdData
);
  logic [HW_LINES-1:0] hwLevel;
  logic [DATA_W-1:0]   statusWord;
  logic [DATA_W-1:0]   causeWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gie     <= 1'b0;
      enField <= '0;
    end else if (strobes.wrStatus) begin
      gie     <= wrGie;
      enField <= wrEnable;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                swPend <= '0;
    else if (strobes.wrCause) swPend <= wrSwPend;
  end

  for (genvar h = 0; h < HW_LINES; h++) begin : g_hwLine
    if (TIMER_ON_TOP && (h == HW_LINES - 1)) begin : g_timerMerge
      assign hwLevel[h] = hwIrq[h] | timerMatch;
    end else begin : g_plain
      assign hwLevel[h] = hwIrq[h];
    end
  end

  if (!TIMER_ON_TOP) begin : g_noTimer
    logic unusedTimer;
    assign unusedTimer = timerMatch;
  end

  assign pendVec = {hwLevel, swPend};

  always_comb begin
    statusWord = '0;
    statusWord[GIE_BIT] = gie;
    statusWord[FIELD_MSB:FIELD_LSB] = enField;
    causeWord = '0;
    causeWord[FIELD_MSB:FIELD_LSB] = pendVec;
  end

  always_comb begin
    if (regAddr == ADDR_W'(ADDR_STATUS))     regRdData = statusWord;
    else if (regAddr == ADDR_W'(ADDR_CAUSE)) regRdData = causeWord;
    else                                     regRdData = '0;
  end
endmodule

// File: rtl/irq_sc_prio.sv
module irq_sc_prio
  import irq_sc_pkg::*;
(
  input  logic [NUM_LINES-1:0] effVec,
  output logic [IDX_W-1:0]     idx,
  output logic                 valid
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (effVec[i]) idx = IDX_W'(i);
    end
  end

  assign valid = |effVec;
endmodule

// File: rtl/irq_status_cause.sv
module irq_status_cause
  import irq_sc_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 32,
  parameter bit TIMER_ON_TOP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [5:0]        hwIrq,
  input  logic              timerMatch,
  input  logic              dispatch,
  output logic              irqReq,
  output logic [2:0]        irqIdx,
  output logic              irqValid,
  output logic              spurious
);
  irq_strobe_t          strobes;
  logic                 gie;
  logic [NUM_LINES-1:0] enField;
  logic [SW_LINES-1:0]  swPend;
  logic [NUM_LINES-1:0] pendVec;
  logic [NUM_LINES-1:0] effVec;
  logic                 unusedWrBits;

  assign unusedWrBits = ^{regWrData[DATA_W-1:FIELD_MSB+1],
                          regWrData[FIELD_LSB-1:GIE_BIT+1]};

  irq_sc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .dispatch (dispatch),
    .effValid (irqValid),
    .strobes  (strobes),
    .spurious (spurious)
  );

  irq_sc_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .TIMER_ON_TOP(TIMER_ON_TOP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regAddr   (regAddr),
    .wrGie     (regWrData[GIE_BIT]),
    .wrEnable  (regWrData[FIELD_MSB:FIELD_LSB]),
    .wrSwPend  (regWrData[FIELD_LSB+SW_LINES-1:FIELD_LSB]),
    .hwIrq     (hwIrq),
    .timerMatch(timerMatch),
    .gie       (gie),
    .enField   (enField),
    .swPend    (swPend),
    .pendVec   (pendVec),
    .regRdData (regRdData)
  );

  assign effVec = pendVec & enField;

  irq_sc_prio u_prio (
    .effVec(effVec),
    .idx   (irqIdx),
    .valid (irqValid)
  );

  assign irqReq = irqValid & gie;
endmodule

// File: rtl/irq_status_cause_chk.sv
module irq_status_cause_chk
  import irq_sc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWrEn,
  input logic [DATA_W-1:0]    regWrData,
  input logic [5:0]           hwIrq,
  input logic                 dispatch,
  input logic                 irqReq,
  input logic [2:0]           irqIdx,
  input logic                 irqValid,
  input logic                 spurious,
  input logic [NUM_LINES-1:0] enField,
  input logic [SW_LINES-1:0]  swPend,
  input logic [NUM_LINES-1:0] pendVec
);
  // R1: first cycle out of reset has no request
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqReq && enField == '0 && swPend == '0));

  // R2: status write lands in the enable field
  assert_status_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADDR_STATUS)) |=>
      (enField == $past(regWrData[FIELD_MSB:FIELD_LSB])));

  // R3: cause write updates only the software bits
  assert_cause_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADDR_CAUSE)) |=>
      (swPend == $past(regWrData[FIELD_LSB+1:FIELD_LSB])));

  // R3: software bits hold without a cause write
  assert_cause_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_W'(ADDR_CAUSE)) |=> $stable(swPend));

  // R4: hardware lines 2..6 mirror their inputs
  assert_hw_mirror_R4: assert property (@(posedge clk) disable iff (!rstN)
    pendVec[6:2] == hwIrq[4:0]);

  // R6: index is zero when nothing is effective
  assert_idle_index_R6: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> (irqIdx == '0));

  // R7: request only with a valid line
  assert_req_needs_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqValid);

  // R8: selected line is pending, enabled and nothing above it is
  assert_top_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (((pendVec & enField) >> irqIdx) == NUM_LINES'(1)));

  // R9: spurious flag only after an empty dispatch
  assert_spurious_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    spurious |-> $past(dispatch && !irqValid));

  // R9: empty dispatch always flags
  assert_spurious_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dispatch && !irqValid) |=> spurious);
endmodule

bind irq_status_cause irq_status_cause_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .hwIrq    (hwIrq),
  .dispatch (dispatch),
  .irqReq   (irqReq),
  .irqIdx   (irqIdx),
  .irqValid (irqValid),
  .spurious (spurious),
  .enField  (enField),
  .swPend   (swPend),
  .pendVec  (pendVec)
);

// File: tb/test_irq_status_cause.sv
module test_irq_status_cause;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic [5:0]        hwIrq = '0;
  logic              timerMatch = 1'b0;
  logic              dispatch = 1'b0;
  logic              irqReq;
  logic [2:0]        irqIdx;
  logic              irqValid;
  logic              spurious;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_status_cause i_irq_status_cause (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .hwIrq(hwIrq),
    .timerMatch(timerMatch), .dispatch(dispatch), .irqReq(irqReq),
    .irqIdx(irqIdx), .irqValid(irqValid), .spurious(spurious)
  );

  // bench model
  logic       mGie = 1'b0;
  logic [7:0] mEn = '0;
  logic [1:0] mSw = '0;

  typedef struct {
    string       tag;
    int          kind;      // 0 status+outputs, 1 cause read, 2 spurious
    logic [31:0] expRd;
    logic        expReq;
    logic [2:0]  expIdx;
    logic        expValid;
    logic        expSpur;
  } item_t;

  item_t scoreQ[$];

  function automatic logic [7:0] modelPend();
    return {hwIrq[5] | timerMatch, hwIrq[4:0], mSw};
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      item_t it;
      wait (scoreQ.size() > 0);
      #1;
      it = scoreQ.pop_front();
      if (it.kind == 0) begin
        cmp(it.tag, "status", regRdData, it.expRd);
        cmp(it.tag, "irqReq", 32'(irqReq), 32'(it.expReq));
        cmp(it.tag, "irqValid", 32'(irqValid), 32'(it.expValid));
        cmp(it.tag, "irqIdx", 32'(irqIdx), 32'(it.expIdx));
      end else if (it.kind == 1) begin
        cmp(it.tag, "cause", regRdData, it.expRd);
      end else begin
        cmp(it.tag, "spurious", 32'(spurious), 32'(it.expSpur));
      end
    end
  end

  task automatic wrReg(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    if (a == 0) begin mGie = d[0]; mEn = d[15:8]; end
    else if (a == 1) mSw = d[9:8];
  endtask

  task automatic checkState(string tag);
    item_t it;
    logic [7:0] eff;
    eff = modelPend() & mEn;
    it.tag = tag; it.kind = 0;
    it.expRd = {16'h0, mEn, 7'h0, mGie};
    it.expValid = (eff != 0);
    it.expIdx = 3'd0;
    for (int i = 0; i < 8; i++) if (eff[i]) it.expIdx = 3'(i);
    it.expReq = it.expValid && mGie;
    it.expSpur = 1'b0;
    regAddr = 2'd0;
    scoreQ.push_back(it);
    #2;
    it.kind = 1;
    it.expRd = {16'h0, modelPend(), 8'h0};
    regAddr = 2'd1;
    scoreQ.push_back(it);
    #2;
  endtask

  task automatic checkSpur(string tag, logic exp);
    item_t it;
    it.tag = tag; it.kind = 2; it.expSpur = exp;
    it.expRd = '0; it.expReq = 0; it.expIdx = 0; it.expValid = 0;
    scoreQ.push_back(it);
    #2;
  endtask

  task automatic pulseDispatch(string tag, logic expSpur);
    @(negedge clk);
    dispatch = 1'b1;
    @(negedge clk);
    dispatch = 1'b0;
    checkSpur(tag, expSpur);
    @(negedge clk);
    checkSpur({tag, "_after"}, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkState("R1_reset");
    checkSpur("R1_reset_spur", 1'b0);

    // R2: status stores bit0 and 15:8 only
    wrReg(2'd0, 32'hFFFF_FFFF);
    checkState("R2_status_all_ones");

    // R3: cause write sets only software bits
    wrReg(2'd1, 32'hFFFF_FFFF);
    checkState("R3_cause_all_ones");

    // R4 R8: hardware lines 2 and 4 pending plus software
    @(negedge clk);
    hwIrq = 6'b000101;
    checkState("R4_hw_mirror_R8_top");

    // R3 R4: software clear leaves hardware bits
    wrReg(2'd1, 32'h0000_0000);
    checkState("R3_sw_clear_R4_hw_stays");

    // R6: only line 2 enabled
    wrReg(2'd0, 32'h0000_0401);
    checkState("R6_mask_line2");

    // R7: global enable off
    wrReg(2'd0, 32'h0000_0400);
    checkState("R7_gie_off");

    // R2: unmapped address write ignored
    wrReg(2'd2, 32'hFFFF_FFFF);
    checkState("R2_unmapped_ignored");

    // R5: timer drives line 7
    @(negedge clk);
    hwIrq = '0; timerMatch = 1'b1;
    wrReg(2'd0, 32'h0000_FF01);
    checkState("R5_timer_line7");
    @(negedge clk);
    timerMatch = 1'b0; hwIrq = 6'b100000;
    checkState("R5_hw_line7");

    // R8: software line 1 vs line 0
    @(negedge clk);
    hwIrq = '0;
    wrReg(2'd1, 32'h0000_0100);
    checkState("R8_line0_only");
    wrReg(2'd1, 32'h0000_0300);
    checkState("R8_line1_over_0");

    // R9: dispatch with a valid line
    pulseDispatch("R9_no_spurious", 1'b0);

    // R9: dispatch with pending but nothing enabled
    @(negedge clk);
    hwIrq = 6'b010010;
    wrReg(2'd0, 32'h0000_0001);
    checkState("R6_pending_none_enabled");
    pulseDispatch("R9_spurious", 1'b1);

    // R8: every line pending and enabled
    @(negedge clk);
    hwIrq = 6'b111111;
    wrReg(2'd0, 32'h0000_FF01);
    checkState("R8_all_lines");

    repeat (2) @(negedge clk);
    wait (scoreQ.size() == 0);
    #3;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule